// File: doc/BRIEF.md
# Burst Write WAIT Generator

This block sits on the device side of a synchronous burst memory. It follows a write burst from the chip-select and address-valid inputs. It holds off the host with a WAIT indication during the programmed latency and then writes a fixed-length run of words into a small storage array. The start address is taken on the first clock edge that sees address-valid low. A beat counter steps through an aligned block of words and wraps inside it. Each beat is written only to the byte lanes that the host enables.

WAIT is presented as an enable plus a value, so no internal tri-state is inferred. The enable follows chip-select. The value is low while data is not yet accepted and goes high one clock before the first data beat. With chip-select held low, a new address-valid pulse after the last beat starts a fresh latency count. An address-valid pulse that arrives in the middle of a burst is not acted on. It sets a sticky error flag. A read port on the array lets the surrounding logic inspect the stored words.

Top module: `burst_wait_gen`

## Requirements
- R1: After reset, wait_oe and proto_err are 0 and every array word reads 0.
- R2: wait_oe is 1 exactly while cs_n is 0; with cs_n high the WAIT pin is released (high-Z).
- R3: While cs_n is low and no burst is running, a fresh address-valid low (adv_n = 0) forces wait_val to 0 at once, and it stays 0 until R4 raises it.
- R4: Call the clock edge that captures a burst E0. wait_val becomes 1 after edge E(LATENCY-1) and not before.
- R5: The words on din are written at edges E(LATENCY) through E(LATENCY+BURST_LEN-1), one beat per edge.
- R6: Beat k goes to address {start[AW-1:2], start[1:0]+k mod 4} for BURST_LEN = 4. The address wraps inside the aligned 4-word block.
- R7: ub_n = 0 enables bits 15:8 and lb_n = 0 enables bits 7:0 of a beat. A beat with both high leaves the word unchanged.
- R8: Address-valid held low over several edges after capture does not restart the latency count and does not flag an error.
- R9: With cs_n held low, a new address-valid after the last beat starts a new burst with the same timing.
- R10: An address-valid falling edge during a running burst is ignored and sets proto_err, which stays 1 until reset.
- R11: Raising cs_n during a burst ends it; no later beats are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Address valid, active low |
| addr | input | AW | Burst start word address |
| ub_n | input | 1 | Upper byte enable, active low |
| lb_n | input | 1 | Lower byte enable, active low |
| din | input | DW | Write data |
| wait_oe | output | 1 | WAIT driver enable (0 = high-Z) |
| wait_val | output | 1 | WAIT level when enabled (1 = data accepted) |
| proto_err | output | 1 | Sticky error for an address-valid during a burst |
| rd_addr | input | AW | Array read address |
| rd_data | output | DW | Array word at rd_addr |

## Verification
The first burst uses an aligned start address with all bytes enabled. It sets the baseline latency and beat ordering. A chained burst starts from a mid-block address and shows whether the address wraps or crosses into the next block. A third burst overwrites earlier words with mixed byte masks, including one fully masked beat, so a wrong lane polarity or a write on a masked beat shows up as corrupted data. The remaining bursts cover the other corners. One holds address-valid low for three edges, one injects a mid-burst address-valid pulse, and one drops chip-select after two beats. These separate a restarted latency count, an error flag that is not sticky, and writes that continue after the burst has been aborted.

// File: rtl/burst_wait_pkg.sv
package burst_wait_pkg;
    typedef enum logic [1:0] {
        BST_IDLE = 2'd0,
        BST_LAT  = 2'd1,
        BST_DATA = 2'd2
    } bst_state_e;
endpackage

// File: rtl/burst_wait_ctrl.sv
module burst_wait_ctrl
    import burst_wait_pkg::*;
#(
    parameter int LATENCY   = 5,
    parameter int BURST_LEN = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cs_n,
    input  logic                          adv_n,
    output logic                          capture,
    output logic                          wr_en,
    output logic [$clog2(BURST_LEN)-1:0]  beat,
    output logic                          ready,
    output logic                          proto_err
);
    localparam int CW = $clog2(LATENCY + 1);
    localparam int BW = $clog2(BURST_LEN);

    typedef struct packed {
        bst_state_e    state;
        logic [CW-1:0] cnt;
        logic [BW-1:0] beat;
        logic          ready;
        logic          arm;
        logic          err;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  fresh_adv;
    logic  busy;

    always_comb begin
        ctl_d     = ctl_q;
        busy      = (ctl_q.state != BST_IDLE);
        fresh_adv = !cs_n && !adv_n && ctl_q.arm;
        capture   = fresh_adv && !busy;
        wr_en     = !cs_n && (ctl_q.state == BST_DATA);

        if (adv_n)
            ctl_d.arm = 1'b1;
        else if (fresh_adv)
            ctl_d.arm = 1'b0;

        if (fresh_adv && busy)
            ctl_d.err = 1'b1;

        if (cs_n) begin
            ctl_d.state = BST_IDLE;
            ctl_d.ready = 1'b0;
            ctl_d.cnt   = '0;
            ctl_d.beat  = '0;
        end else begin
            unique case (ctl_q.state)
                BST_IDLE: begin
                    if (capture) begin
                        ctl_d.state = BST_LAT;
                        ctl_d.cnt   = CW'(1);
                        ctl_d.beat  = '0;
                        ctl_d.ready = 1'b0;
                    end
                end
                BST_LAT: begin
                    ctl_d.cnt = ctl_q.cnt + CW'(1);
                    if (ctl_q.cnt == CW'(LATENCY - 1)) begin
                        ctl_d.state = BST_DATA;
                        ctl_d.ready = 1'b1;
                        ctl_d.beat  = '0;
                    end
                end
                BST_DATA: begin
                    ctl_d.beat = ctl_q.beat + BW'(1);
                    if (ctl_q.beat == BW'(BURST_LEN - 1))
                        ctl_d.state = BST_IDLE;
                end
                default: ctl_d.state = BST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= BST_IDLE;
            ctl_q.arm   <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign beat      = ctl_q.beat;
    assign ready     = ctl_q.ready;
    assign proto_err = ctl_q.err;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
    parameter int AW        = 6,
    parameter int BURST_LEN = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          capture,
    input  logic [AW-1:0]                 addr,
    input  logic [$clog2(BURST_LEN)-1:0]  beat,
    output logic [AW-1:0]                 wr_addr
);
    localparam int WB = $clog2(BURST_LEN);

    logic [AW-1:0] base_d, base_q;
    logic [WB-1:0] low_sum;

    always_comb begin
        base_d  = capture ? addr : base_q;
        low_sum = base_q[WB-1:0] + beat;
    end

    generate
        if (WB < AW) begin : g_split
            assign wr_addr = {base_q[AW-1:WB], low_sum};
        end else begin : g_whole
            assign wr_addr = low_sum;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) base_q <= '0;
        else        base_q <= base_d;
    end
endmodule

// File: rtl/burst_byte_store.sv
module burst_byte_store #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [1:0]    lane_en,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;
    localparam int LW    = DW / 2;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] bit_en;

    generate
        for (genvar b = 0; b < 2; b++) begin : g_lane
            assign bit_en[b*LW +: LW] = {LW{lane_en[b]}};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_addr] <= (mem_q[wr_addr] & ~bit_en) | (wr_data & bit_en);
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/burst_wait_gen.sv
module burst_wait_gen #(
    parameter int AW        = 6,
    parameter int DW        = 16,
    parameter int LATENCY   = 5,
    parameter int BURST_LEN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          adv_n,
    input  logic [AW-1:0] addr,
    input  logic          ub_n,
    input  logic          lb_n,
    input  logic [DW-1:0] din,
    output logic          wait_oe,
    output logic          wait_val,
    output logic          proto_err,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int BW = $clog2(BURST_LEN);

    logic          capture;
    logic          wr_en;
    logic [BW-1:0] beat;
    logic          ready;
    logic [AW-1:0] wr_addr;
    logic [1:0]    lane_en;

    burst_wait_ctrl #(.LATENCY(LATENCY), .BURST_LEN(BURST_LEN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .adv_n(adv_n),
        .capture(capture), .wr_en(wr_en), .beat(beat),
        .ready(ready), .proto_err(proto_err)
    );

    burst_addr_gen #(.AW(AW), .BURST_LEN(BURST_LEN)) u_addr (
        .clk(clk), .rst_n(rst_n), .capture(capture), .addr(addr),
        .beat(beat), .wr_addr(wr_addr)
    );

    assign lane_en = {!ub_n, !lb_n};

    burst_byte_store #(.AW(AW), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .lane_en(lane_en), .wr_data(din), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign wait_oe  = !cs_n;
    assign wait_val = ready && !capture;
endmodule

// File: rtl/burst_wait_gen_chk.sv
module burst_wait_gen_chk #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          wait_oe,
    input logic          wait_val,
    input logic          proto_err,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [AW-1:0] rd_addr,
    input logic [DW-1:0] rd_data
);
    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    // R11
    no_write_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !wr_en);

    // R4
    write_needs_wait_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wait_oe && wait_val));

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |->
        (wr_addr[1:0] == 2'($past(wr_addr[1:0]) + 2'd1)) &&
        (wr_addr[AW-1:2] == $past(wr_addr[AW-1:2])));

    // R7
    idle_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en ##1 $stable(rd_addr)) |-> $stable(rd_data));
endmodule

bind burst_wait_gen burst_wait_gen_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wait_oe(wait_oe),
    .wait_val(wait_val), .proto_err(proto_err), .wr_en(wr_en),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/burst_wait_gen_bench.sv
module burst_wait_gen_bench;
    localparam int AW  = 6;
    localparam int DW  = 16;
    localparam int LAT = 5;
    localparam int BL  = 4;

    typedef struct {
        int          a;
        logic [15:0] exp;
        string       req;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          adv_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          ub_n = 1'b1;
    logic          lb_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic          wait_oe, wait_val, proto_err;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;

    int errors = 0;
    int checks = 0;
    int pending = 0;
    logic [15:0] model [64];
    item_t sb_q [$];

    always #2 clk = ~clk;

    burst_wait_gen #(.AW(AW), .DW(DW), .LATENCY(LAT), .BURST_LEN(BL)) u_burst_wait_gen (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .adv_n(adv_n), .addr(addr),
        .ub_n(ub_n), .lb_n(lb_n), .din(din), .wait_oe(wait_oe),
        .wait_val(wait_val), .proto_err(proto_err), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_beat(input int a, input logic [15:0] d, input logic u, input logic l,
                             input string req);
        item_t it;
        if (!u) model[a][15:8] = d[15:8];
        if (!l) model[a][7:0]  = d[7:0];
        it.a = a; it.exp = model[a]; it.req = req;
        pending++;
        sb_q.push_back(it);
    endtask

    // monitor: pops each expected word after its write edge and compares
    initial begin
        forever begin
            item_t it;
            wait (sb_q.size() > 0);
            it = sb_q.pop_front();
            @(posedge clk);
            @(negedge clk);
            rd_addr = AW'(it.a);
            #1;
            check(rd_data == it.exp, it.req, int'(rd_data), int'(it.exp));
            pending--;
        end
    end

    task automatic do_burst(input int a, input logic [15:0] base, input logic [3:0] um,
                            input logic [3:0] lm, input int adv_hold, input bit inject,
                            input string req);
        cs_n = 1'b0; adv_n = 1'b0; addr = AW'(a);
        #1;
        check(wait_oe == 1'b1, "R2", int'(wait_oe), 1);
        check(wait_val == 1'b0, "R3", int'(wait_val), 0);
        for (int k = 0; k <= LAT + BL - 1; k++) begin
            int j;
            @(posedge clk);
            @(negedge clk);
            if (k == LAT - 2) check(wait_val == 1'b0, "R4", int'(wait_val), 0);
            if (k == LAT - 1) check(wait_val == 1'b1, "R4", int'(wait_val), 1);
            if (k + 1 >= adv_hold) adv_n = 1'b1;
            if (inject && k == 1) adv_n = 1'b0;
            j = k - LAT + 1;
            if (j >= 0 && j < BL) begin
                din = base + 16'(j * 16'h0101);
                ub_n = um[j]; lb_n = lm[j];
                push_beat(((a & ~3) | ((a + j) & 3)), din, um[j], lm[j], req);
            end else begin
                ub_n = 1'b1; lb_n = 1'b1;
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(wait_oe == 1'b0, "R1", int'(wait_oe), 0);
        check(proto_err == 1'b0, "R1", int'(proto_err), 0);
        rd_addr = 6'd9; #1;
        check(rd_data == 16'h0, "R1", int'(rd_data), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: aligned full burst
        do_burst(8, 16'h1100, 4'b0000, 4'b0000, 1, 1'b0, "R5");
        check(wait_val == 1'b1, "R9", int'(wait_val), 1);
        // R9, R6: chained burst from mid-block, wraps 6,7,4,5
        do_burst(6, 16'h2200, 4'b0000, 4'b0000, 1, 1'b0, "R6");
        // R7: overwrite 9,10,11,8 with masks; beat2 fully masked
        do_burst(9, 16'hA050, 4'b0101, 4'b1100, 1, 1'b0, "R7");
        // R8: adv held low for three edges
        do_burst(12, 16'h3300, 4'b0000, 4'b0000, 3, 1'b0, "R8");
        check(proto_err == 1'b0, "R8", int'(proto_err), 0);
        // R10: adv pulse during burst is ignored, flag set
        do_burst(16, 16'h4400, 4'b0000, 4'b0000, 1, 1'b1, "R10");
        check(proto_err == 1'b1, "R10", int'(proto_err), 1);

        cs_n = 1'b1;
        #1;
        check(wait_oe == 1'b0, "R2", int'(wait_oe), 0);
        repeat (2) @(negedge clk);

        // R11: abort after two beats
        cs_n = 1'b0; adv_n = 1'b0; addr = AW'(20);
        for (int k = 0; k < LAT + BL + 2; k++) begin
            @(posedge clk);
            @(negedge clk);
            adv_n = 1'b1;
            din = 16'h5500 + 16'(k);
            ub_n = 1'b0; lb_n = 1'b0;
            if (k == LAT - 1 || k == LAT)
                push_beat(20 + k - LAT + 1, din, 1'b0, 1'b0, "R11");
            if (k == LAT + 1) begin
                cs_n = 1'b1;
                push_beat(22, 16'h0, 1'b1, 1'b1, "R11");
                push_beat(23, 16'h0, 1'b1, 1'b1, "R11");
            end
        end
        check(proto_err == 1'b1, "R10", int'(proto_err), 1);
        ub_n = 1'b1; lb_n = 1'b1;
        wait (pending == 0);
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule